// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block gathers eight interrupt request lines into a single interrupt output for a host processor. For every input it keeps three state bits: a pending bit for requests that wait for acknowledge, an in-service bit for requests the host is handling, and a mask bit that keeps the input from being forwarded. Each input can be set to detect either a rising edge or a level. Priority is either fixed or rotating.

The host answers the interrupt with a one-cycle acknowledge pulse. The block then returns an 8-bit vector: a programmable base plus the winning level. If nothing is eligible at acknowledge time, it returns the vector of the lowest level as a spurious interrupt. The host finishes a handler with a non-specific end-of-interrupt strobe. Instead, auto-EOI mode can release the level at acknowledge. A small register port with write and registered read sets the mask, vector base, mode bits and trigger selection, and exposes the pending and in-service state.

All inputs, including the request lines, are synchronous to `clk`. `NUM_IRQ` must be a power of two.

Top module: `irq_merge_ctrl`

## Requirements
- R1: After a synchronous reset, `int_out` and `vec_valid` are 0. Mask, mode, trigger select, pending and in-service all read 0. The vector base reads 0x20.
- R2: On an edge-triggered input (trigger select bit 0), a 0-to-1 change sets the pending bit. The bit stays set after the line falls, until the level wins an acknowledge.
- R3: On a level-triggered input (trigger select bit 1), the pending bit follows the input line. It is cleared only in the cycle that level wins an acknowledge.
- R4: A masked input still records pending (mask bit 1 = masked). It never raises `int_out` and never wins an acknowledge.
- R5: In fixed mode, level 0 has the highest priority and level 7 the lowest.
- R6: `int_out` is 1 one cycle after the state shows an unmasked pending request that outranks every in-service level. `int_out` is 0 otherwise.
- R7: An acknowledge makes `int_out` 0 on the next cycle and pulses `vec_valid` for one cycle with `vec_out` = base + winner. It also clears the winner's pending bit and sets its in-service bit.
- R8: If no unmasked pending request outranks the in-service levels at acknowledge, `vec_out` = base + 7. No in-service bit is set and no pending bit is cleared.
- R9: An EOI strobe clears only the highest-priority in-service bit. With nothing in service it has no effect.
- R10: In rotating mode (mode bit 0), the level released by EOI becomes the lowest priority. The levels after it, in ascending wrap-around order, become the highest.
- R11: In auto-EOI mode (mode bit 1), an acknowledge sets no in-service bit. With rotation enabled, the acknowledged level becomes the lowest priority.
- R12: Register addresses: 0 mask, 1 vector base, 2 mode, 3 trigger select, 4 pending (read-only), 5 in-service (read-only). Other addresses read 0. Writes to 4 and 5 are ignored. `cfg_rdata` shows the register at `cfg_addr` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Interrupt request lines, level 0 to 7 |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Registered read data |
| eoi | input | 1 | Non-specific end-of-interrupt strobe |
| ack | input | 1 | One-cycle interrupt acknowledge |
| int_out | output | 1 | Interrupt request to the host |
| vec_valid | output | 1 | Vector valid, one cycle after acknowledge |
| vec_out | output | 8 | Returned interrupt vector |

## Verification
A request line change reaches the pending bit at the next edge. It shows on `int_out` one edge later, and on the read port one edge after the address is presented. Acknowledge and EOI alter the in-service bits at the edge where they are sampled. The vector and `vec_valid` appear at that same edge. The bench drives every input at the falling edge and keeps a cycle model that advances at each rising edge. It compares `int_out`, the vector and the read data at every following falling edge, so each result is checked exactly in the cycle it is due. Directed sequences add explicit checks for nesting, rotation, spurious acknowledge and masking.

// File: rtl/pic_pkg.sv
package pic_pkg;

  typedef enum logic [2:0] {
    REG_MASK = 3'd0,
    REG_BASE = 3'd1,
    REG_MODE = 3'd2,
    REG_TRIG = 3'd3,
    REG_PEND = 3'd4,
    REG_INSV = 3'd5
  } reg_addr_e;

  // mode register layout: bit 1 auto release, bit 0 rotating priority
  typedef struct packed {
    logic auto_eoi;
    logic rotate;
  } mode_t;

endpackage

// File: rtl/pic_prio_pick.sv
// Picks the highest-priority set bit. The lowest-priority level is `low`;
// priority rank 0 belongs to level low+1 (wrapping).
module pic_prio_pick #(
  parameter int NUM_IRQ = 8,
  localparam int LW = $clog2(NUM_IRQ)
) (
  input  logic [NUM_IRQ-1:0] req,
  input  logic [LW-1:0]      low,
  output logic               found,
  output logic [LW-1:0]      lvl,
  output logic [LW:0]        rank
);

  always_comb begin
    logic [LW-1:0] idx;
    found = 1'b0;
    lvl   = '0;
    rank  = (LW+1)'(NUM_IRQ);
    // scan from lowest rank to highest; the last hit is the best
    for (int k = NUM_IRQ - 1; k >= 0; k--) begin
      idx = low + LW'(1) + LW'(k);
      if (req[idx]) begin
        found = 1'b1;
        lvl   = idx;
        rank  = (LW+1)'(k);
      end
    end
  end

endmodule

// File: rtl/pic_req_capture.sv
// Request latching: edge or level detection per input, cleared by acknowledge.
module pic_req_capture #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic [NUM_IRQ-1:0] level_sel,
  input  logic [NUM_IRQ-1:0] clr,
  output logic [NUM_IRQ-1:0] pend_q
);

  logic [NUM_IRQ-1:0] irq_q;
  logic [NUM_IRQ-1:0] pend_nxt;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
    assign pend_nxt[i] = level_sel[i]
                       ? (irq_in[i] & ~clr[i])
                       : ((pend_q[i] & ~clr[i]) | (irq_in[i] & ~irq_q[i]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= '0;
      pend_q <= '0;
    end else begin
      irq_q  <= irq_in;
      pend_q <= pend_nxt;
    end
  end

endmodule

// File: rtl/pic_service.sv
// In-service register, end-of-interrupt release and priority rotation.
module pic_service #(
  parameter int NUM_IRQ = 8,
  localparam int LW = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rotate,
  input  logic               auto_eoi,
  input  logic               eoi,
  input  logic               take,
  input  logic [LW-1:0]      take_lvl,
  output logic [NUM_IRQ-1:0] isr_q,
  output logic [LW-1:0]      eff_low,
  output logic [LW:0]        isr_rank
);

  logic [LW-1:0]      low_q;
  logic               isr_found;
  logic [LW-1:0]      isr_lvl;
  logic               eoi_hit;
  logic [NUM_IRQ-1:0] clr_vec;
  logic [NUM_IRQ-1:0] set_vec;

  assign eff_low = rotate ? low_q : LW'(NUM_IRQ - 1);

  pic_prio_pick #(.NUM_IRQ(NUM_IRQ)) u_isr_pick (
    .req   (isr_q),
    .low   (eff_low),
    .found (isr_found),
    .lvl   (isr_lvl),
    .rank  (isr_rank)
  );

  assign eoi_hit = eoi & isr_found;
  assign clr_vec = eoi_hit ? (NUM_IRQ'(1) << isr_lvl) : '0;
  assign set_vec = (take & ~auto_eoi) ? (NUM_IRQ'(1) << take_lvl) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q <= '0;
      low_q <= LW'(NUM_IRQ - 1);
    end else begin
      isr_q <= (isr_q & ~clr_vec) | set_vec;
      if (rotate) begin
        if (eoi_hit) begin
          low_q <= isr_lvl;
        end else if (take && auto_eoi) begin
          low_q <= take_lvl;
        end
      end
    end
  end

endmodule

// File: rtl/irq_merge_ctrl.sv
module irq_merge_ctrl
  import pic_pkg::*;
#(
  parameter int            NUM_IRQ    = 8,
  parameter int            VEC_W      = 8,
  parameter logic [VEC_W-1:0] RESET_BASE = 8'h20,
  localparam int LW     = $clog2(NUM_IRQ),
  localparam int DATA_W = (NUM_IRQ > VEC_W) ? NUM_IRQ : VEC_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_addr,
  input  logic [DATA_W-1:0]  cfg_wdata,
  output logic [DATA_W-1:0]  cfg_rdata,
  input  logic               eoi,
  input  logic               ack,
  output logic               int_out,
  output logic               vec_valid,
  output logic [VEC_W-1:0]   vec_out
);

  logic [NUM_IRQ-1:0] mask_q;
  logic [NUM_IRQ-1:0] trig_q;
  logic [VEC_W-1:0]   base_q;
  mode_t              mode_q;

  logic [NUM_IRQ-1:0] pend_q;
  logic [NUM_IRQ-1:0] isr_q;
  logic [NUM_IRQ-1:0] pend_clr;
  logic [LW-1:0]      eff_low;
  logic [LW:0]        isr_rank;
  logic               p_found;
  logic [LW-1:0]      p_lvl;
  logic [LW:0]        p_rank;
  logic               int_req;
  logic               take;

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      trig_q <= '0;
      base_q <= RESET_BASE;
      mode_q <= '0;
    end else if (cfg_we) begin
      case (reg_addr_e'(cfg_addr))
        REG_MASK: mask_q <= cfg_wdata[NUM_IRQ-1:0];
        REG_BASE: base_q <= cfg_wdata[VEC_W-1:0];
        REG_MODE: mode_q <= mode_t'(cfg_wdata[1:0]);
        REG_TRIG: trig_q <= cfg_wdata[NUM_IRQ-1:0];
        default: ;
      endcase
    end
  end

  pic_req_capture #(.NUM_IRQ(NUM_IRQ)) u_capture (
    .clk       (clk),
    .rst       (rst),
    .irq_in    (irq_in),
    .level_sel (trig_q),
    .clr       (pend_clr),
    .pend_q    (pend_q)
  );

  pic_prio_pick #(.NUM_IRQ(NUM_IRQ)) u_req_pick (
    .req   (pend_q & ~mask_q),
    .low   (eff_low),
    .found (p_found),
    .lvl   (p_lvl),
    .rank  (p_rank)
  );

  assign int_req  = p_found && (p_rank < isr_rank);
  assign take     = ack & int_req;
  assign pend_clr = take ? (NUM_IRQ'(1) << p_lvl) : '0;

  pic_service #(.NUM_IRQ(NUM_IRQ)) u_service (
    .clk      (clk),
    .rst      (rst),
    .rotate   (mode_q.rotate),
    .auto_eoi (mode_q.auto_eoi),
    .eoi      (eoi),
    .take     (take),
    .take_lvl (p_lvl),
    .isr_q    (isr_q),
    .eff_low  (eff_low),
    .isr_rank (isr_rank)
  );

  // host-facing outputs, all registered
  always_ff @(posedge clk) begin
    if (rst) begin
      int_out   <= 1'b0;
      vec_valid <= 1'b0;
      vec_out   <= '0;
      cfg_rdata <= '0;
    end else begin
      int_out   <= ack ? 1'b0 : int_req;
      vec_valid <= ack;
      if (ack) begin
        vec_out <= base_q + (take ? VEC_W'(p_lvl) : VEC_W'(NUM_IRQ - 1));
      end
      case (reg_addr_e'(cfg_addr))
        REG_MASK: cfg_rdata <= DATA_W'(mask_q);
        REG_BASE: cfg_rdata <= DATA_W'(base_q);
        REG_MODE: cfg_rdata <= DATA_W'(mode_q);
        REG_TRIG: cfg_rdata <= DATA_W'(trig_q);
        REG_PEND: cfg_rdata <= DATA_W'(pend_q);
        REG_INSV: cfg_rdata <= DATA_W'(isr_q);
        default:  cfg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
  parameter int NUM_IRQ = 8,
  parameter int VEC_W   = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               ack,
  input logic               eoi,
  input logic               int_out,
  input logic               vec_valid,
  input logic [VEC_W-1:0]   vec_out,
  input logic [VEC_W-1:0]   base,
  input logic [NUM_IRQ-1:0] pend,
  input logic [NUM_IRQ-1:0] mask,
  input logic [NUM_IRQ-1:0] isr,
  input logic               auto_eoi
);

  logic [VEC_W-1:0] spur_v;
  logic             no_req;
  assign spur_v = base + VEC_W'(NUM_IRQ - 1);
  assign no_req = ((pend & ~mask) == '0);

  // R7
  ack_drops_int_chk: assert property (@(posedge clk) disable iff (rst)
    ack |=> !int_out);

  // R7
  vec_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ack |=> vec_valid);

  // R7
  vec_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !ack |=> !vec_valid);

  // R8
  spur_vec_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && no_req) |=> (vec_out == $past(spur_v)));

  // R8
  spur_no_service_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && no_req && !eoi) |=> $stable(isr));

  // R11
  auto_no_service_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && auto_eoi && !eoi) |=> $stable(isr));

  // R9
  isr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ack && !eoi) |=> $stable(isr));

  // R9
  eoi_clears_one_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi && !ack && (isr != '0)) |=> ($countones(isr) == $countones($past(isr)) - 1));

  // R4
  int_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    int_out |-> $past(!no_req));

endmodule

bind irq_merge_ctrl pic_chk #(.NUM_IRQ(NUM_IRQ), .VEC_W(VEC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ack       (ack),
  .eoi       (eoi),
  .int_out   (int_out),
  .vec_valid (vec_valid),
  .vec_out   (vec_out),
  .base      (base_q),
  .pend      (pend_q),
  .mask      (mask_q),
  .isr       (isr_q),
  .auto_eoi  (mode_q.auto_eoi)
);

// File: tb/tb_irq_merge_ctrl.sv
module tb_irq_merge_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_in = '0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       eoi = 1'b0;
  logic       ack = 1'b0;
  logic       int_out;
  logic       vec_valid;
  logic [7:0] vec_out;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  irq_merge_ctrl dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .eoi(eoi), .ack(ack),
    .int_out(int_out), .vec_valid(vec_valid), .vec_out(vec_out)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [7:0] m_pend, m_isr, m_mask, m_trig, m_base, m_prev, m_vec, m_rd;
  logic [1:0] m_mode;
  logic [2:0] m_low;
  logic       m_int, m_vv, m_spur;

  // returns {found, level}
  function automatic logic [3:0] best(input logic [7:0] v, input logic [2:0] el);
    best = 4'd0;
    for (int k = 7; k >= 0; k--) begin
      logic [2:0] idx;
      idx = el + 3'd1 + 3'(k);
      if (v[idx]) best = {1'b1, idx};
    end
  endfunction

  function automatic logic [3:0] rnk(input logic [3:0] b, input logic [2:0] el);
    rnk = b[3] ? {1'b0, b[2:0] - el - 3'd1} : 4'd8;
  endfunction

  logic [2:0] s_el;
  logic [3:0] s_bp, s_bs;
  logic       s_req, s_take;
  logic [7:0] s_clr, s_eclr, s_set, s_np;

  always @(posedge clk) begin
    if (rst) begin
      m_pend <= '0; m_isr <= '0; m_mask <= '0; m_trig <= '0; m_base <= 8'h20;
      m_prev <= '0; m_vec <= '0; m_rd <= '0; m_mode <= '0; m_low <= 3'd7;
      m_int <= 1'b0; m_vv <= 1'b0; m_spur <= 1'b0;
    end else begin
      s_el   = m_mode[0] ? m_low : 3'd7;
      s_bp   = best(m_pend & ~m_mask, s_el);
      s_bs   = best(m_isr, s_el);
      s_req  = s_bp[3] && (rnk(s_bp, s_el) < rnk(s_bs, s_el));
      s_take = ack && s_req;
      s_clr  = s_take ? (8'd1 << s_bp[2:0]) : 8'd0;
      for (int i = 0; i < 8; i++)
        s_np[i] = m_trig[i] ? (irq_in[i] & ~s_clr[i])
                            : ((m_pend[i] & ~s_clr[i]) | (irq_in[i] & ~m_prev[i]));
      s_eclr = (eoi && s_bs[3]) ? (8'd1 << s_bs[2:0]) : 8'd0;
      s_set  = (s_take && !m_mode[1]) ? s_clr : 8'd0;
      m_pend <= s_np;
      m_isr  <= (m_isr & ~s_eclr) | s_set;
      if (m_mode[0]) begin
        if (eoi && s_bs[3]) m_low <= s_bs[2:0];
        else if (s_take && m_mode[1]) m_low <= s_bp[2:0];
      end
      m_int <= ack ? 1'b0 : s_req;
      m_vv  <= ack;
      if (ack) begin
        m_vec  <= m_base + (s_take ? {5'd0, s_bp[2:0]} : 8'd7);
        m_spur <= !s_take;
      end
      case (cfg_addr)
        3'd0: m_rd <= m_mask;
        3'd1: m_rd <= m_base;
        3'd2: m_rd <= {6'd0, m_mode};
        3'd3: m_rd <= m_trig;
        3'd4: m_rd <= m_pend;
        3'd5: m_rd <= m_isr;
        default: m_rd <= '0;
      endcase
      if (cfg_we) begin
        case (cfg_addr)
          3'd0: m_mask <= cfg_wdata;
          3'd1: m_base <= cfg_wdata;
          3'd2: m_mode <= cfg_wdata[1:0];
          3'd3: m_trig <= cfg_wdata;
          default: ;
        endcase
      end
      m_prev <= irq_in;
    end
  end

  // cycle-by-cycle comparison away from the rising edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R6 int_out", {7'd0, int_out}, {7'd0, m_int});
      chk("R7 vec_valid", {7'd0, vec_valid}, {7'd0, m_vv});
      if (m_vv) chk(m_spur ? "R8 spurious vector" : "R7 vector", vec_out, m_vec);
      chk("R12 read data", cfg_rdata, m_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); cfg_addr = a;
    @(negedge clk); v = cfg_rdata;
  endtask

  task automatic pulse(input logic [7:0] b);
    @(negedge clk); irq_in = b;
    @(negedge clk); irq_in = '0;
  endtask

  task automatic do_ack(output logic [7:0] v);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0; v = vec_out;
  endtask

  task automatic do_eoi();
    @(negedge clk); eoi = 1'b1;
    @(negedge clk); eoi = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    chk("R1 int_out", {7'd0, int_out}, 8'd0);
    chk("R1 vec_valid", {7'd0, vec_valid}, 8'd0);
    rd(3'd0, v); chk("R1 mask", v, 8'h00);
    rd(3'd1, v); chk("R1 base", v, 8'h20);
    rd(3'd2, v); chk("R1 mode", v, 8'h00);
    rd(3'd3, v); chk("R1 trigger", v, 8'h00);
    rd(3'd4, v); chk("R1 pending", v, 8'h00);
    rd(3'd5, v); chk("R1 in-service", v, 8'h00);

    // R2 edge request held after the line falls
    pulse(8'h08); idle(2);
    rd(3'd4, v); chk("R2 pending held", v, 8'h08);
    chk("R6 int raised", {7'd0, int_out}, 8'd1);

    // R5 fixed priority, R7 acknowledge, R6 nesting
    pulse(8'h90); idle(1);
    do_ack(v); chk("R5 level 3 wins", v, 8'h23);
    idle(2);
    rd(3'd5, v); chk("R7 in-service set", v, 8'h08);
    rd(3'd4, v); chk("R7 pending cleared", v, 8'h90);
    chk("R6 lower level held off", {7'd0, int_out}, 8'd0);

    // R9 EOI clears highest in-service
    do_eoi(); idle(2);
    chk("R6 int after eoi", {7'd0, int_out}, 8'd1);
    do_ack(v); chk("R5 level 4 next", v, 8'h24);
    do_ack(v); chk("R8 level 7 not above 4", v, 8'h27);
    rd(3'd5, v); chk("R8 no level 7 in service", v, 8'h10);
    do_eoi(); rd(3'd5, v); chk("R9 cleared level 4", v, 8'h00);
    rd(3'd4, v); chk("R8 pending 7 kept", v, 8'h80);
    do_ack(v); chk("R7 level 7 vector", v, 8'h27);
    do_eoi(); do_eoi();
    rd(3'd5, v); chk("R9 eoi on empty", v, 8'h00);

    // R8 spurious with nothing pending
    do_ack(v); chk("R8 spurious vector", v, 8'h27);
    rd(3'd5, v); chk("R8 in-service untouched", v, 8'h00);

    // R4 masking
    wr(3'd0, 8'h01); pulse(8'h01); idle(2);
    chk("R4 masked no int", {7'd0, int_out}, 8'd0);
    rd(3'd4, v); chk("R4 masked still pending", v, 8'h01);
    do_ack(v); chk("R4 masked not granted", v, 8'h27);
    wr(3'd0, 8'h00); idle(2);
    chk("R4 unmask raises int", {7'd0, int_out}, 8'd1);
    do_ack(v); chk("R4 unmasked vector", v, 8'h20);
    do_eoi();

    // R3 level trigger
    wr(3'd3, 8'h04);
    @(negedge clk); irq_in = 8'h04; idle(2);
    rd(3'd4, v); chk("R3 level pending", v, 8'h04);
    chk("R3 level int", {7'd0, int_out}, 8'd1);
    @(negedge clk); irq_in = 8'h00; idle(2);
    rd(3'd4, v); chk("R3 level dropped", v, 8'h00);
    chk("R3 int dropped", {7'd0, int_out}, 8'd0);

    // R10 rotating priority
    wr(3'd2, 8'h01);
    pulse(8'h01); idle(1);
    do_ack(v); chk("R10 first grant", v, 8'h20);
    do_eoi();
    pulse(8'h03); idle(1);
    do_ack(v); chk("R10 level 1 above level 0", v, 8'h21);
    do_eoi(); idle(1);
    do_ack(v); chk("R10 level 0 afterwards", v, 8'h20);
    do_eoi();

    // R11 auto-EOI
    wr(3'd2, 8'h02);
    pulse(8'h20); idle(1);
    do_ack(v); chk("R11 auto vector", v, 8'h25);
    rd(3'd5, v); chk("R11 no in-service", v, 8'h00);
    rd(3'd4, v); chk("R11 pending cleared", v, 8'h00);

    // R12 register port
    wr(3'd1, 8'h40);
    rd(3'd1, v); chk("R12 base readback", v, 8'h40);
    wr(3'd4, 8'hFF);
    rd(3'd4, v); chk("R12 pending write ignored", v, 8'h00);
    wr(3'd5, 8'hFF);
    rd(3'd5, v); chk("R12 in-service write ignored", v, 8'h00);
    rd(3'd6, v); chk("R12 unused address", v, 8'h00);
    do_ack(v); chk("R8 spurious uses new base", v, 8'h47);

    // constrained random phase, checked by the model
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      if ($urandom_range(3) == 0) irq_in = 8'($urandom);
      ack      = ($urandom_range(5) == 0);
      eoi      = !ack && ($urandom_range(5) == 0);
      cfg_we   = ($urandom_range(23) == 0);
      cfg_addr = 3'($urandom_range(6));
      cfg_wdata = 8'($urandom);
    end
    @(negedge clk);
    ack = 1'b0; eoi = 1'b0; cfg_we = 1'b0; irq_in = '0;
    idle(3);
    finish_run();
  end

endmodule